// File: doc/BRIEF.md
# Retriggerable Period Timer with Compare Channels

This block is an up-counting timer. It steps from zero to a selectable TOP value and then begins again at zero. The period limit can come from three places: a build-time constant, a software-loaded capture register, or compare register 0. If retrigger is enabled, an external capture event counts as reaching TOP, so an outside edge can end the current period early and start a new one.

The block has a number of compare channels set by a parameter. Each channel tests the count against its own register on every timer tick. A match raises a sticky flag. The flag can raise an interrupt when that channel's enable bit is set. A flag is cleared by an acknowledge input or by writing a one to its bit.

The block also gives out two one-cycle status pulses, one for the TOP condition and one for the BOTTOM condition, for use by downstream waveform logic. All counting is qualified by a tick enable, so a prescaler outside the block sets the timer rate.

Top module: `rtr_timer`

## Requirements
- R1: The count rises by one on every cycle where `tick_i` is high and the TOP condition does not hold. The count does not change on a cycle where `tick_i` is low.
- R2: On a tick where the count equals the active TOP value, the count is 0 in the next cycle and `top_o` is high for that one cycle.
- R3: The TOP source is chosen by control register (address 0) bits [1:0]. Value 0 or 3 selects the `FIXED_TOP` parameter, 1 selects the capture register (address 2), and 2 selects compare register 0 (address 3).
- R4: When control bit 2 (retrigger) is set, a tick that has `capt_evt_i` high acts as a TOP condition: the count goes to 0 and `top_o` pulses. When retrigger is clear, `capt_evt_i` has no effect.
- R5: `bottom_o` is high in the cycle after any tick on which the count was 0.
- R6: Compare channel i uses the register at address 3+i. A tick on which the count equals that register sets `flag_o[i]` in the next cycle. A flag never becomes set without a tick.
- R7: `irq_o[i]` is high exactly when `flag_o[i]` is high and interrupt enable bit i, which is control bit 3+i, is set.
- R8: A high `irq_ack_i[i]`, or a write to address 1 that has data bit i set, clears `flag_o[i]` in the next cycle. Zero bits in that write leave the flags unchanged.
- R9: When a flag-set event and a clear request for the same channel occur in one cycle, the flag ends up set.
- R10: When TOP comes from a register that holds 0, the count stays at 0 and `top_o` pulses after every tick.
- R11: A high `rst_i` at a clock edge clears the count, the control, capture and compare registers, all flags and both status pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| capt_evt_i | input | 1 | Capture event (used as retrigger) |
| irq_ack_i | input | N_CH | Per-channel interrupt acknowledge |
| count_o | output | CNT_W | Current count |
| top_o | output | 1 | TOP-reached pulse |
| bottom_o | output | 1 | BOTTOM pulse |
| flag_o | output | N_CH | Compare flags |
| irq_o | output | N_CH | Interrupt requests |

## Verification
A wrong TOP source select or a wrong wrap comparison shows up at `count_o` within one period of the selected TOP. It also shows up as the wrong number of `top_o` pulses over a run of ticks. A wrong compare or flag state shows up at `flag_o` one cycle after the matching tick, and at `irq_o` in that same cycle. Clear-versus-set priority is exercised by asserting acknowledge on the same tick that produces a match.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam logic [1:0] TOP_FIXED  = 2'd0;
  localparam logic [1:0] TOP_CAPT   = 2'd1;
  localparam logic [1:0] TOP_CMPA   = 2'd2;
  localparam logic [1:0] TOP_FIXED2 = 2'd3;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_FLAGS = 1;
  localparam int unsigned ADDR_CAPT  = 2;
  localparam int unsigned ADDR_CMP0  = 3;

  localparam int unsigned CTRL_RETRIG_BIT = 2;
  localparam int unsigned CTRL_IE_LSB     = 3;
endpackage

// File: rtl/rtr_regs.sv
module rtr_regs
  import rtr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [CNT_W-1:0]            wr_data_i,
  output logic [1:0]                  top_sel_o,
  output logic                        retrig_o,
  output logic [N_CH-1:0]             ie_o,
  output logic [CNT_W-1:0]            capt_o,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [N_CH-1:0]             clr_o
);
  logic ctrl_we, capt_we, flag_we;

  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign capt_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CAPT));
  assign flag_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FLAGS));
  assign clr_o   = flag_we ? wr_data_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      top_sel_o <= TOP_FIXED;
      retrig_o  <= 1'b0;
      ie_o      <= '0;
      capt_o    <= '0;
    end else begin
      if (ctrl_we) begin
        top_sel_o <= wr_data_i[1:0];
        retrig_o  <= wr_data_i[CTRL_RETRIG_BIT];
        ie_o      <= wr_data_i[CTRL_IE_LSB +: N_CH];
      end
      if (capt_we) capt_o <= wr_data_i;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_cmp
    always_ff @(posedge clk_i) begin
      if (rst_i)
        cmp_o[i] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP0 + i)))
        cmp_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rtr_counter.sv
module rtr_counter
  import rtr_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter logic [CNT_W-1:0] FIXED_TOP = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [1:0]       top_sel_i,
  input  logic             retrig_i,
  input  logic             capt_evt_i,
  input  logic [CNT_W-1:0] capt_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic [CNT_W-1:0] count_o,
  output logic             top_o,
  output logic             bottom_o
);
  logic [CNT_W-1:0] top_val;
  logic             top_hit;

  always_comb begin
    case (top_sel_i)
      TOP_CAPT: top_val = capt_i;
      TOP_CMPA: top_val = cmpa_i;
      default:  top_val = FIXED_TOP;
    endcase
  end

  // retrigger is merged into the wrap condition
  assign top_hit = (count_o == top_val) || (retrig_i && capt_evt_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o  <= '0;
      top_o    <= 1'b0;
      bottom_o <= 1'b0;
    end else begin
      top_o    <= tick_i && top_hit;
      bottom_o <= tick_i && (count_o == '0);
      if (tick_i) count_o <= top_hit ? '0 : count_o + 1'b1;
    end
  end
endmodule

// File: rtl/rtr_cmp_ch.sv
module rtr_cmp_ch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  input  logic             ie_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic set_ev;

  assign set_ev = tick_i && (count_i == cmp_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_o <= 1'b0;
    else       flag_o <= set_ev || (flag_o && !clr_i);
  end

  assign irq_o = flag_o && ie_i;
endmodule

// File: rtl/rtr_timer.sv
module rtr_timer
  import rtr_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_CH      = 2,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [CNT_W-1:0] FIXED_TOP = '1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              capt_evt_i,
  input  logic [N_CH-1:0]   irq_ack_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic [N_CH-1:0]   flag_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [1:0]                 top_sel;
  logic                       retrig_en;
  logic [N_CH-1:0]            ie;
  logic [CNT_W-1:0]           capt_val;
  logic [N_CH-1:0][CNT_W-1:0] cmp_val;
  logic [N_CH-1:0]            wr_clr;

  rtr_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .top_sel_o(top_sel), .retrig_o(retrig_en),
    .ie_o(ie), .capt_o(capt_val), .cmp_o(cmp_val), .clr_o(wr_clr)
  );

  rtr_counter #(.CNT_W(CNT_W), .FIXED_TOP(FIXED_TOP)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .top_sel_i(top_sel),
    .retrig_i(retrig_en), .capt_evt_i(capt_evt_i), .capt_i(capt_val),
    .cmpa_i(cmp_val[0]), .count_o(count_o), .top_o(top_o), .bottom_o(bottom_o)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    rtr_cmp_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .count_i(count_o),
      .cmp_i(cmp_val[i]), .clr_i(wr_clr[i] || irq_ack_i[i]), .ie_i(ie[i]),
      .flag_o(flag_o[i]), .irq_o(irq_o[i])
    );
  end
endmodule

// File: rtl/rtr_timer_chk.sv
module rtr_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_i,
  input logic             capt_evt_i,
  input logic             retrig_en,
  input logic [N_CH-1:0]  irq_ack_i,
  input logic [CNT_W-1:0] count_o,
  input logic             top_o,
  input logic             bottom_o,
  input logic [N_CH-1:0]  flag_o,
  input logic [N_CH-1:0]  irq_o
);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(count_o));

  // R2
  top_means_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    top_o |-> count_o == '0);

  // R4
  retrig_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && retrig_en && capt_evt_i) |=> (top_o && count_o == '0));

  // R5
  bottom_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && count_o == '0) |=> bottom_o);

  // R6
  no_flag_without_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> (flag_o & ~$past(flag_o)) == '0);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o & ~flag_o) == '0);

  // R8
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && irq_ack_i != '0) |=> (flag_o & $past(irq_ack_i)) == '0);

  // R11
  reset_clears_chk: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0 && flag_o == '0 && !top_o && !bottom_o));
endmodule

bind rtr_timer rtr_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .capt_evt_i(capt_evt_i),
  .retrig_en(retrig_en), .irq_ack_i(irq_ack_i), .count_o(count_o),
  .top_o(top_o), .bottom_o(bottom_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/rtr_timer_bench.sv
module rtr_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int N_CH  = 2;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] topv;
    logic [15:0] n;
    logic [15:0] exp_cnt;
    logic [7:0]  exp_tops;
  } vec_t;

  // fixed TOP is 12 in this bench
  localparam vec_t VECS [7] = '{
    '{2'd0, 16'd0, 16'd30, 16'd4, 8'd2},
    '{2'd1, 16'd5, 16'd20, 16'd2, 8'd3},
    '{2'd2, 16'd7, 16'd17, 16'd1, 8'd2},
    '{2'd3, 16'd0, 16'd13, 16'd0, 8'd1},
    '{2'd1, 16'd0, 16'd5,  16'd0, 8'd5},
    '{2'd2, 16'd0, 16'd4,  16'd0, 8'd4},
    '{2'd1, 16'd1, 16'd7,  16'd1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic capt = 1'b0;
  logic [N_CH-1:0] ack = '0;
  logic [CNT_W-1:0] count;
  logic top, bottom;
  logic [N_CH-1:0] flag, irq;

  int total = 0;
  int bad = 0;
  int tops;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtr_timer #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W), .FIXED_TOP(16'd12)) u_rtr_timer (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .capt_evt_i(capt), .irq_ack_i(ack), .count_o(count),
    .top_o(top), .bottom_o(bottom), .flag_o(flag), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step();
      if (top) tops++;
    end
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step();
    do_reset();
    // R11 reset state
    check("R11 count", count, 0);
    check("R11 flags", flag, 0);
    check("R11 irq", irq, 0);
    check("R11 top/bottom", {top, bottom}, 0);

    // table: TOP sources, wrap, zero TOP
    for (int v = 0; v < 7; v++) begin
      do_reset();
      wr(2, VECS[v].topv);
      wr(3, VECS[v].topv);
      wr(0, VECS[v].sel);
      tops = 0;
      tick_n(VECS[v].n);
      check($sformatf("R3 R2 R10 row%0d count", v), count, VECS[v].exp_cnt);
      check($sformatf("R2 R10 row%0d tops", v), tops, VECS[v].exp_tops);
    end

    // directed
    do_reset();
    step(); step(); step(); step();
    check("R1 idle hold", count, 0);
    check("R6 no tick no flag", flag, 0);
    tick = 1'b1; step(); tick = 1'b0;
    check("R1 one tick", count, 1);
    check("R5 bottom pulse", bottom, 1);
    check("R6 both match at 0", flag, 2'b11);
    check("R7 irq masked", irq, 0);
    step();
    check("R5 bottom one cycle", bottom, 0);

    wr(1, 0);
    check("R8 zero write keeps", flag, 2'b11);
    wr(1, 1);
    check("R8 w1c bit0", flag, 2'b10);
    ack = 2'b10; step(); ack = '0;
    check("R8 ack clears", flag, 0);

    wr(0, 2 << 3);          // fixed TOP, ie ch1
    wr(4, 3);
    tick_n(2);
    check("R1 count 3", count, 3);
    check("R6 no early match", flag, 0);
    tick_n(1);
    check("R6 ch1 match", flag, 2'b10);
    check("R7 irq ch1", irq, 2'b10);

    wr(3, 4);
    ack = 2'b01; tick = 1'b1; step(); ack = '0; tick = 1'b0;
    check("R9 set beats clear", flag, 2'b11);
    check("R7 irq ch0 masked", irq, 2'b10);
    check("R1 count 5", count, 5);

    wr(0, (2 << 3) | 4);    // retrigger on
    capt = 1'b1; tick = 1'b1; step(); capt = 1'b0; tick = 1'b0;
    check("R4 retrig count", count, 0);
    check("R4 retrig top", top, 1);
    wr(0, 2 << 3);          // retrigger off
    capt = 1'b1; tick = 1'b1; step(); capt = 1'b0; tick = 1'b0;
    check("R4 ignored count", count, 1);
    check("R4 ignored top", top, 0);

    rst = 1'b1; step(); rst = 1'b0;
    check("R11 count cleared", count, 0);
    check("R11 flags cleared", flag, 0);
    check("R11 irq cleared", irq, 0);

    finish_run();
  end
endmodule